// File: doc/BRIEF.md
# Cascadable Dual-Mode LED Serial Loader

This block is the serial input stage of a 16-channel LED driver. One shift register takes serial data from `sin` on each rising edge of `sclk`. The same register serves two loading modes. With `mode` high it collects a 6-bit brightness trim for every channel. With `mode` low it collects a 12-bit PWM level for every channel. A pulse on `xlat` copies the collected data into the holding register that `mode` selects. The holding registers drive the rest of the chip.

Several devices can form one long shift path. Each device's `sout` connects to the next device's `sin`. `sout` always comes from the live shift register, tapped at the end of the active mode's frame: 96 bits in trim mode and 192 bits in PWM mode. It never comes from a holding register. Because of this, the first trim frame after power-up or after a PWM latch arrives intact at every device in the chain. No leading dummy clock and no repeated frame are needed.

All pins are sampled by the system clock `clk`. `sclk` and `xlat` edges are found by comparing each pin with its value one cycle earlier. Reset is synchronous and active low.

Top module: `led_serial_loader`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it, every 6-bit trim field in `dc_word` reads 6'h3F, `gs_word` reads 0, `sout` reads 0 and the shift register holds all zeros.
- R2: Each rising edge of `sclk` shifts `sin` into bit 0 of the shift register and moves every bit up by one place. After a frame of L bits is sent most significant bit first, bit L-1 of the frame sits at shift position L-1. Channel c occupies bits [c*W+W-1 : c*W], so channel 15's MSB is the first bit sent.
- R3: A rising edge of `xlat` with `mode` high and `sclk` low copies shift bits [95:0] into `dc_word`. `gs_word` is left unchanged.
- R4: A rising edge of `xlat` with `mode` low and `sclk` low copies shift bits [191:0] into `gs_word`. `dc_word` is left unchanged.
- R5: A rising edge of `xlat` while `sclk` is high is ignored: neither holding register changes.
- R6: In trim mode `sout` presents shift bit 95, and in PWM mode it presents shift bit 191. It follows that bit one cycle after any cycle in which `sclk` is low. It holds its value while `sclk` stays high.
- R7: In a chain of two devices, a trim frame of 192 bits loads its first 96 bits into the far device and its last 96 bits into the near device. A PWM frame of 384 bits splits the same way. This holds for the first trim frame after reset and for the first trim frame after a PWM latch, including channel 15's MSB.
- R8: A change of `mode` while `sclk` is low switches `sout` to the new mode's shift-register tap one cycle later, before the next `sclk` rise. The switch never exposes holding-register contents.
- R9: Shifting alone never changes `dc_word` or `gs_word`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock, idle low; data is captured on its rising edge |
| sin | input | 1 | Serial data in |
| mode | input | 1 | 1 = trim loading, 0 = PWM level loading |
| xlat | input | 1 | Latch strobe; its rising edge transfers data to the selected holding register |
| sout | output | 1 | Cascade data out to the next device's `sin` |
| dc_word | output | 96 | Trim holding register, channel c at bits [6c+5:6c] |
| gs_word | output | 192 | PWM holding register, channel c at bits [12c+11:12c] |

## Verification
- An `sclk` rise seen at a `clk` edge updates the shift register at that same edge. An `xlat` rise with `sclk` low updates the selected holding register at that same edge. Both results are visible one cycle later.
- `sout` is reloaded at every edge where `sclk` is low. It is therefore due one cycle after `sclk` falls or `mode` changes.
- The bench drives every pin phase for two cycles on the falling edge of `clk` and samples only at the end of a phase, so each result has at least one spare cycle.
- The checker compares each result with the state one cycle earlier through `$past`, which matches this one-register delay.

// File: rtl/led_ld_pkg.sv
// Package: default geometry shared by the loader and its checker.
// Assumes: the PWM frame is never shorter than the trim frame.
package led_ld_pkg;
    localparam int unsigned LD_CHANNELS = 16;
    localparam int unsigned LD_DC_W     = 6;
    localparam int unsigned LD_GS_W     = 12;
endpackage

// File: rtl/led_ld_edge.sv
// Module: detects pin edges of the serial clock and latch strobe.
// Assumes: sclk and xlat are already synchronous to clk. A latch counts
// only when sclk is low at the strobe's rising edge.
module led_ld_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic xlat,
    output logic sclk_rise,
    output logic sclk_low,
    output logic latch_fire
);
    logic sclk_q;
    logic xlat_q;

    // Purpose: keep the previous pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            xlat_q <= 1'b0;
        end else begin
            sclk_q <= sclk;
            xlat_q <= xlat;
        end
    end

    // Purpose: decode edges and the latch qualifier.
    always_comb begin
        sclk_rise  = sclk & ~sclk_q;
        sclk_low   = ~sclk;
        latch_fire = xlat & ~xlat_q & ~sclk;
    end
endmodule

// File: rtl/led_ld_shift.sv
// Module: the single serial shift register shared by both loading modes.
// Assumes: shift_en is a one-cycle pulse per serial clock rise.
module led_ld_shift #(
    parameter int unsigned LEN = 192
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] q
);
    // Purpose: move data up one place and take the new bit at the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[LEN-2:0], din};
        end
    end
endmodule

// File: rtl/led_ld_bank.sv
// Module: holding register loaded in parallel from the shift register.
// Assumes: load is a one-cycle pulse; INIT is the value after reset.
module led_ld_bank #(
    parameter int unsigned W    = 96,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Purpose: capture the shifted frame on a qualified latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= INIT;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/led_ld_sout.sv
// Module: cascade output. It taps the live shift register at the end of
// the active mode's frame.
// Assumes: it is reloaded every cycle that sclk is low, so the value seen by
// the next device on a rise is at most one cycle old and never comes
// from a holding register.
module led_ld_sout #(
    parameter int unsigned LEN    = 192,
    parameter int unsigned DC_LEN = 96
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sclk_low,
    input  logic           mode,
    input  logic [LEN-1:0] shreg,
    output logic           sout
);
    logic tap_bit;

    // Purpose: pick the tap; the two frames may be equal in length.
    generate
        if (DC_LEN == LEN) begin : g_same_tap
            always_comb tap_bit = shreg[LEN-1];
        end else begin : g_two_taps
            always_comb tap_bit = mode ? shreg[DC_LEN-1] : shreg[LEN-1];
        end
    endgenerate

    // Purpose: follow the tap while sclk is low and hold it while sclk is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sout <= 1'b0;
        end else if (sclk_low) begin
            sout <= tap_bit;
        end
    end
endmodule

// File: rtl/led_serial_loader.sv
// Module: top of the dual-mode serial loader.
// Assumes: mode changes only while xlat is low, and pins are synchronous to clk.
module led_serial_loader #(
    parameter int unsigned CHANNELS = led_ld_pkg::LD_CHANNELS,
    parameter int unsigned DC_W     = led_ld_pkg::LD_DC_W,
    parameter int unsigned GS_W     = led_ld_pkg::LD_GS_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk,
    input  logic                     sin,
    input  logic                     mode,
    input  logic                     xlat,
    output logic                     sout,
    output logic [CHANNELS*DC_W-1:0] dc_word,
    output logic [CHANNELS*GS_W-1:0] gs_word
);
    localparam int unsigned DC_LEN = CHANNELS * DC_W;
    localparam int unsigned GS_LEN = CHANNELS * GS_W;

    logic              sclk_rise;
    logic              sclk_low;
    logic              latch_fire;
    logic [GS_LEN-1:0] shreg;

    led_ld_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk       (sclk),
        .xlat       (xlat),
        .sclk_rise  (sclk_rise),
        .sclk_low   (sclk_low),
        .latch_fire (latch_fire)
    );

    led_ld_shift #(.LEN(GS_LEN)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sclk_rise),
        .din      (sin),
        .q        (shreg)
    );

    led_ld_bank #(.W(DC_LEN), .INIT({DC_LEN{1'b1}})) u_dc_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (latch_fire & mode),
        .d     (shreg[DC_LEN-1:0]),
        .q     (dc_word)
    );

    led_ld_bank #(.W(GS_LEN), .INIT({GS_LEN{1'b0}})) u_gs_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (latch_fire & ~mode),
        .d     (shreg),
        .q     (gs_word)
    );

    led_ld_sout #(.LEN(GS_LEN), .DC_LEN(DC_LEN)) u_sout (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_low (sclk_low),
        .mode     (mode),
        .shreg    (shreg),
        .sout     (sout)
    );
endmodule

// File: rtl/led_serial_loader_chk.sv
// Module: property checker bound to every loader instance.
// Assumes: it sees the internal shift register through the bind.
module led_serial_loader_chk #(
    parameter int unsigned CHANNELS = 16,
    parameter int unsigned DC_W     = 6,
    parameter int unsigned GS_W     = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sclk,
    input logic                     mode,
    input logic                     xlat,
    input logic                     sout,
    input logic [CHANNELS*DC_W-1:0] dc_word,
    input logic [CHANNELS*GS_W-1:0] gs_word,
    input logic [CHANNELS*GS_W-1:0] shreg
);
    localparam int unsigned DC_LEN = CHANNELS * DC_W;
    localparam int unsigned GS_LEN = CHANNELS * GS_W;

    assert_sout_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sclk)) |-> $stable(sout));

    assert_sout_dc_tap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sclk) && $past(mode)) |-> sout == $past(shreg[DC_LEN-1]));

    assert_sout_gs_tap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sclk) && !$past(mode)) |-> sout == $past(shreg[GS_LEN-1]));

    assert_dc_only_on_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(dc_word)) |-> $past(xlat && mode && !sclk));

    assert_gs_only_on_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$stable(gs_word)) |-> $past(xlat && !mode && !sclk));

    assert_dc_content_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 2) && $past(rst_n) && $past(xlat) && !$past(xlat, 2)
         && !$past(sclk) && $past(mode)) |-> dc_word == $past(shreg[DC_LEN-1:0]));

    assert_latch_ignored_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sclk)) |-> ($stable(dc_word) && $stable(gs_word)));
endmodule

bind led_serial_loader led_serial_loader_chk #(
    .CHANNELS (CHANNELS),
    .DC_W     (DC_W),
    .GS_W     (GS_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (sclk),
    .mode    (mode),
    .xlat    (xlat),
    .sout    (sout),
    .dc_word (dc_word),
    .gs_word (gs_word),
    .shreg   (shreg)
);

// File: tb/led_serial_loader_test.sv
`timescale 1ns/1ps
module led_serial_loader_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sin = 1'b0;
    logic mode = 1'b0;
    logic xlat = 1'b0;
    logic sout, sout2;
    logic [95:0]  dc_word, dc_word2;
    logic [191:0] gs_word, gs_word2;
    int checks = 0;
    int errors = 0;
    logic [95:0]  exp_dc;
    logic [191:0] exp_gs;

    always #2.5 clk = ~clk;

    led_serial_loader uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sin(sin), .mode(mode), .xlat(xlat),
        .sout(sout), .dc_word(dc_word), .gs_word(gs_word));

    led_serial_loader uut_far (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sin(sout), .mode(mode), .xlat(xlat),
        .sout(sout2), .dc_word(dc_word2), .gs_word(gs_word2));

    // mode bit, pattern seed
    localparam logic [32:0] VEC [6] = '{
        {1'b1, 32'h1234_5678}, {1'b0, 32'hCAFE_0001}, {1'b1, 32'h0BAD_F00D},
        {1'b0, 32'h7777_AAAA}, {1'b0, 32'h0000_0003}, {1'b1, 32'hFFFF_0000}};

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [191:0] mk(input logic [31:0] s);
        logic [191:0] v;
        logic [31:0]  h;
        for (int i = 0; i < 192; i++) begin
            h = s ^ (32'(i) * 32'h9E37_79B9);
            h = h ^ (h >> 15);
            v[i] = ^(h & 32'h2C9A_5B37);
        end
        return v;
    endfunction

    task automatic send_bit(input logic b);
        sin = b; sclk = 1'b1; tick(); tick();
        sclk = 1'b0; tick(); tick();
    endtask

    task automatic send_frame(input logic [383:0] f, input int len);
        for (int i = len - 1; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic pulse_latch();
        xlat = 1'b1; tick(); tick();
        xlat = 1'b0; tick(); tick();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [95:0]  far_a, near_b;
        logic [191:0] gfar, gnear, f;
        tick(); tick(); tick();
        // R1: values while in reset
        check("R1 dc reset", 192'(dc_word), 192'({96{1'b1}}));
        check("R1 gs reset", gs_word, '0);
        rst_n = 1'b1; tick();
        check("R1 sout reset", 192'(sout), 192'(0));
        exp_dc = '1; exp_gs = '0;

        // R7: first trim frame after reset through a two-device chain
        mode = 1'b1; tick();
        far_a = mk(32'hA5A5_0001)[95:0]; far_a[95] = 1'b1;
        near_b = mk(32'h5A5A_0002)[95:0];
        send_frame({192'd0, far_a, near_b}, 192);
        check("R9 no load on shift", 192'(dc_word), 192'(exp_dc));
        pulse_latch();
        check("R7 far dc after reset", 192'(dc_word2), 192'(far_a));
        check("R7 near dc after reset", 192'(dc_word), 192'(near_b));
        exp_dc = near_b;

        // R7: PWM latch, then the first trim frame must keep ch15 MSB
        mode = 1'b0; tick();
        gfar = mk(32'h0F0F_1111); gnear = mk(32'hF0F0_2222);
        send_frame({gfar, gnear}, 384);
        pulse_latch();
        check("R7 far gs", gs_word2, gfar);
        check("R4 near gs", gs_word, gnear);
        exp_gs = gnear;
        mode = 1'b1; tick();
        far_a = mk(32'h3333_4444)[95:0]; far_a[95] = 1'b1;
        near_b = mk(32'h5555_6666)[95:0];
        send_frame({192'd0, far_a, near_b}, 192);
        pulse_latch();
        check("R7 far ch15 msb after gs latch", 192'(dc_word2[95]), 192'(1));
        check("R7 far dc after gs latch", 192'(dc_word2), 192'(far_a));
        exp_dc = near_b;

        // R2 R3 R4 R9: vector table
        for (int k = 0; k < 6; k++) begin
            mode = VEC[k][32]; tick();
            f = mk(VEC[k][31:0]);
            send_frame({192'd0, f}, VEC[k][32] ? 96 : 192);
            check("R9 shift leaves dc", 192'(dc_word), 192'(exp_dc));
            check("R9 shift leaves gs", gs_word, exp_gs);
            pulse_latch();
            if (VEC[k][32]) exp_dc = f[95:0];
            else            exp_gs = f;
            check(VEC[k][32] ? "R3 dc latch" : "R4 gs latch", 192'(dc_word), 192'(exp_dc));
            check(VEC[k][32] ? "R3 gs kept" : "R2 gs frame", gs_word, exp_gs);
        end

        // R6 R8: tap per mode, mode switch while sclk low
        mode = 1'b0; tick();
        f = mk(32'h2468_ACE0); f[191] = 1'b1; f[95] = 1'b0; f[94] = 1'b1;
        send_frame({192'd0, f}, 192);
        check("R6 gs tap", 192'(sout), 192'(1));
        mode = 1'b1; tick(); tick();
        check("R8 dc tap after switch", 192'(sout), 192'(0));
        check("R8 dc kept", 192'(dc_word), 192'(exp_dc));
        sin = 1'b0; sclk = 1'b1; tick(); tick();
        check("R6 hold while sclk high", 192'(sout), 192'(0));
        sclk = 1'b0; tick(); tick();
        check("R6 update after fall", 192'(sout), 192'(1));

        // R5: latch while sclk high is ignored
        sclk = 1'b1; tick();
        xlat = 1'b1; tick(); tick();
        xlat = 1'b0; tick();
        sclk = 1'b0; tick(); tick();
        check("R5 dc unchanged", 192'(dc_word), 192'(exp_dc));
        check("R5 gs unchanged", gs_word, exp_gs);

        // R1: reset again from a loaded state
        rst_n = 1'b0; tick(); tick();
        rst_n = 1'b1; tick();
        check("R1 dc after reset", 192'(dc_word), 192'({96{1'b1}}));
        check("R1 gs after reset", gs_word, '0);
        check("R1 sout after reset", 192'(sout), 192'(0));
        mode = 1'b0; tick();
        send_bit(1'b0);
        check("R1 shift cleared", 192'(sout), 192'(0));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule